// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM. The host raises a request strobe with a read/write flag, an address and, for writes, a data word. The controller then drives the memory's chip-enable, write-enable, output-enable and address pins, and the enable of the data bus, through a timed sequence. When the access is over it raises a one-cycle done pulse. For reads, the captured word is on the read-data port during that pulse.

Every phase length is a whole number of clock cycles. The count is worked out at elaboration as the ceiling of a nanosecond minimum divided by the clock period `CLK_NS`, and is never less than one. A write is ended by write-enable rising while chip-enable stays low. Output-enable stays high for the whole write, and one idle-bus cycle comes before the controller drives data. Together these keep the memory and the controller from driving the bus at the same time.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is held low, memCeN, memWeN and memOeN are 1, and memDqOe and rspDone are 0.
- R2: A read holds memCeN and memOeN at 0 and memWeN at 1 for exactly RD_CYC cycles. RD_CYC is the largest of ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) and ceil(T_DOE_NS/CLK_NS). It is 2 with the defaults 12, 12, 5 and CLK_NS=10.
- R3: A write holds memWeN at 0 for exactly WE_CYC cycles. WE_CYC is the largest of ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-2 and 1. It is 1 with the defaults. memCeN stays 0 and memOeN stays 1 during the pulse.
- R4: During a write, memDqOut is driven (memDqOe=1) and stable for the whole write-enable-low window and for the cycle after write-enable rises. memAddr stays constant while memCeN is 0.
- R5: memDqOe is never 1 while memOeN is 0. A write starts with one cycle of memCeN=0 and memDqOe=0 before write-enable falls.
- R6: rspDone is a one-cycle pulse. Count from the clock edge that accepts the request. For a read, rspDone appears in cycle RD_CYC+1, and rspRdata then holds the memory word sampled on the last edge of the read phase. For a write, rspDone appears in cycle WE_CYC+2.
- R7: A request presented while an access is in progress is ignored. memAddr does not change, and the memory is not written.
- R8: A write ends by memWeN rising while memCeN is still 0. memCeN rises one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspRdata | output | DATA_W | Last word read |
| rspDone | output | 1 | One-cycle completion pulse |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDqOut | output | DATA_W | Data toward the memory |
| memDqOe | output | 1 | Drive enable for the data pads |
| memDqIn | input | DATA_W | Data from the memory pads |

## Verification
The bench pairs the controller with a memory model. The model returns a corrupted word until output-enable and chip-enable have been low for the full read count. A design that captures a cycle early therefore reads back inverted data. The model writes only when write-enable rises, and it checks at that moment the pulse length, how long the data has been stable, and that chip-enable and the data drive are still held. A design that ends writes with chip-enable, or drops the data as write-enable rises, is reported there. The bench sweeps every address with two patterns and runs reads and writes back to back, so the read-to-write turnaround is exercised and any overlap of output-enable with data drive is caught. It also sends conflicting requests while the controller is busy. A controller that accepted them would move the address or overwrite a word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RREL, S_WSET, S_WPUL, S_WEND
  } ctrlState_e;

  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic dqOe;
    logic done;
  } pinSet_t;

  typedef struct packed {
    logic    load;
    logic    capture;
    pinSet_t pins;
  } strobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int readCycles(input int aa, input int rc, input int doe, input int clkNs);
    return maxInt(maxInt(nsToCyc(aa, clkNs), nsToCyc(rc, clkNs)), nsToCyc(doe, clkNs));
  endfunction

  function automatic int writeCycles(input int pwe, input int sd, input int wc, input int clkNs);
    return maxInt(maxInt(nsToCyc(pwe, clkNs), nsToCyc(sd, clkNs)),
                  maxInt(nsToCyc(wc, clkNs) - 2, 1));
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WE_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t stb
);

  localparam int CNT_MAX = maxInt(RD_CYC, WE_CYC) - 1;
  localparam int CNT_W   = (CNT_MAX > 0) ? $clog2(CNT_MAX + 1) : 1;

  ctrlState_e       state, stateNxt;
  logic [CNT_W-1:0] cnt;
  pinSet_t          pinsQ;

  function automatic pinSet_t decode(input ctrlState_e s);
    pinSet_t p;
    p = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, dqOe: 1'b0, done: 1'b0};
    case (s)
      S_RD:    begin p.ceN = 1'b0; p.oeN = 1'b0; end
      S_RREL:  p.done = 1'b1;
      S_WSET:  p.ceN = 1'b0;
      S_WPUL:  begin p.ceN = 1'b0; p.weN = 1'b0; p.dqOe = 1'b1; end
      S_WEND:  begin p.ceN = 1'b0; p.dqOe = 1'b1; p.done = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:  if (reqValid) stateNxt = reqWrite ? S_WSET : S_RD;
      S_RD:    if (cnt == '0) stateNxt = S_RREL;
      S_RREL:  stateNxt = S_IDLE;
      S_WSET:  stateNxt = S_WPUL;
      S_WPUL:  if (cnt == '0) stateNxt = S_WEND;
      S_WEND:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      pinsQ <= decode(S_IDLE);
    end else begin
      state <= stateNxt;
      pinsQ <= decode(stateNxt);
      if (stateNxt == S_RD && state != S_RD)
        cnt <= CNT_W'(RD_CYC - 1);
      else if (stateNxt == S_WPUL && state != S_WPUL)
        cnt <= CNT_W'(WE_CYC - 1);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    stb.load    = (state == S_IDLE) && reqValid;
    stb.capture = (state == S_RD) && (cnt == '0);
    stb.pins    = pinsQ;
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.capture)
        rdataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 12,
  parameter int T_RC_NS   = 12,
  parameter int T_DOE_NS  = 5,
  parameter int T_WC_NS   = 12,
  parameter int T_PWE_NS  = 8,
  parameter int T_SD_NS   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC = readCycles(T_AA_NS, T_RC_NS, T_DOE_NS, CLK_NS);
  localparam int WE_CYC = writeCycles(T_PWE_NS, T_SD_NS, T_WC_NS, CLK_NS);

  strobe_t stb;

  sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC)) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .stb      (stb)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .rspRdata (rspRdata)
  );

  assign memCeN  = stb.pins.ceN;
  assign memWeN  = stb.pins.weN;
  assign memOeN  = stb.pins.oeN;
  assign memDqOe = stb.pins.dqOe;
  assign rspDone = stb.pins.done;

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 2,
  parameter int WE_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspDone,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut
);

  int weLowCnt;
  int oeLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt <= 0;
      oeLowCnt <= 0;
    end else begin
      weLowCnt <= memWeN ? 0 : weLowCnt + 1;
      oeLowCnt <= memOeN ? 0 : oeLowCnt + 1;
    end
  end

  p_read_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowCnt == RD_CYC));

  p_read_no_we_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

  p_write_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == WE_CYC));

  p_write_oe_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDqOut));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_turn_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> !memDqOe);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_we_ends_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && memDqOe));

endmodule

bind sram_port_ctrl sram_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rspDone  (rspDone),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memDqOe  (memDqOe),
  .memAddr  (memAddr),
  .memDqOut (memDqOut)
);

// File: tb/tb_sram_port_ctrl.sv
module tb_sram_port_ctrl;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NWORDS = 1 << AW;
  localparam int CLKNS = 10;
  // expected phase counts, from the nanosecond minima
  localparam int RD_A = (12 + CLKNS - 1) / CLKNS;
  localparam int RD_B = (5 + CLKNS - 1) / CLKNS;
  localparam int RD_EXP = (RD_A > RD_B) ? RD_A : RD_B;
  localparam int WE_A = (8 + CLKNS - 1) / CLKNS;
  localparam int WE_B = (12 + CLKNS - 1) / CLKNS - 2;
  localparam int WE_C = (WE_A > WE_B) ? WE_A : WE_B;
  localparam int WE_EXP = (WE_C > 1) ? WE_C : 1;
  localparam int SD_EXP = (7 + CLKNS - 1) / CLKNS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspRdata;
  logic rspDone, memCeN, memWeN, memOeN, memDqOe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDqOut, memDqIn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_port_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKNS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rspDone(rspDone), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural memory model, sampled at falling edges
  logic [DW-1:0] mem [NWORDS];
  int rdAge = 0;
  int weCnt = 0;
  int sdCnt = 0;
  logic [DW-1:0] dqSeen = '0;

  assign memDqIn = (!memCeN && !memOeN && rdAge >= RD_EXP) ? mem[memAddr] : ~mem[memAddr];

  always @(negedge clk) begin
    if (rstN) begin
      rdAge <= (!memCeN && !memOeN) ? rdAge + 1 : 0;
      if (memDqOe && !memOeN)
        chk(1'b0, "R5", "bus contention", 32'(memOeN), 32'h1);
      if (!memCeN && !memWeN) begin
        weCnt <= weCnt + 1;
        if (memDqOe) begin
          sdCnt  <= (weCnt > 0 && memDqOut != dqSeen) ? 1 : sdCnt + 1;
          dqSeen <= memDqOut;
        end else begin
          sdCnt <= 0;
        end
      end else if (weCnt > 0) begin
        chk(weCnt >= WE_EXP, "R3", "write pulse cycles", 32'(weCnt), 32'(WE_EXP));
        chk(sdCnt >= SD_EXP, "R4", "data setup cycles", 32'(sdCnt), 32'(SD_EXP));
        chk(!memCeN && memDqOe && memDqOut == dqSeen, "R8", "ce/data held at write end",
            {memCeN, memDqOe, 30'(memDqOut)}, {2'b01, 30'(dqSeen)});
        mem[memAddr] <= dqSeen;
        weCnt <= 0;
        sdCnt <= 0;
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input bit inv);
    logic [DW-1:0] v;
    v = DW'(a * 16'h0101) ^ 16'h5A3C;
    return inv ? ~v : v;
  endfunction

  // one access; noise = cycles of conflicting request while busy (R7)
  task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                        input int noise, output logic [DW-1:0] rd);
    int n;
    int expLat;
    expLat = wr ? WE_EXP + 2 : RD_EXP + 1;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWdata = d;
    @(posedge clk);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n <= noise) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a + 1); reqWdata = ~d;
        if (n > 1)
          chk(memAddr == AW'(a), "R7", "address moved on busy request", 32'(memAddr), 32'(a));
      end else begin
        reqValid = 1'b0;
      end
      if (rspDone || n > 40) break;
    end
    reqValid = 1'b0;
    chk(n == expLat, "R6", wr ? "write done latency" : "read done latency", 32'(n), 32'(expLat));
    rd = rspRdata;
    @(negedge clk);
    chk(!rspDone, "R6", "done pulse width", 32'(rspDone), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run hung", 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    for (int i = 0; i < NWORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({memCeN, memWeN, memOeN, memDqOe, rspDone} == 5'b11100, "R1", "reset pins",
        32'({memCeN, memWeN, memOeN, memDqOe, rspDone}), 32'h1C);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({memCeN, memWeN, memOeN, memDqOe} == 4'b1110, "R1", "idle pins after reset",
        32'({memCeN, memWeN, memOeN, memDqOe}), 32'hE);

    // R3 R4 R8: write every address
    for (int a = 0; a < NWORDS; a++) access(1'b1, a, pat(a, 1'b0), 0, r);
    // R2: read every address back
    for (int a = 0; a < NWORDS; a++) begin
      access(1'b0, a, '0, 0, r);
      chk(r == pat(a, 1'b0), "R2", "read data", 32'(r), 32'(pat(a, 1'b0)));
    end
    // R5: back-to-back read then write with the inverse pattern, then read
    for (int a = 0; a < NWORDS; a++) begin
      access(1'b0, a, '0, 0, r);
      access(1'b1, a, pat(a, 1'b1), 0, r);
      access(1'b0, a, '0, 0, r);
      chk(r == pat(a, 1'b1), "R5", "read after turnaround", 32'(r), 32'(pat(a, 1'b1)));
    end
    // R7: conflicting requests during busy read and write are ignored
    for (int a = 0; a < NWORDS - 1; a += 9) begin
      access(1'b0, a, '0, RD_EXP, r);
      chk(r == pat(a, 1'b1), "R7", "read under busy noise", 32'(r), 32'(pat(a, 1'b1)));
      access(1'b1, a, pat(a, 1'b0), WE_EXP + 1, r);
      access(1'b0, a + 1, '0, 0, r);
      chk(r == pat(a + 1, 1'b1), "R7", "neighbour not written", 32'(r), 32'(pat(a + 1, 1'b1)));
      access(1'b0, a, '0, 0, r);
      chk(r == pat(a, 1'b0), "R7", "own write landed", 32'(r), 32'(pat(a, 1'b0)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule